// File: doc/BRIEF.md
# Scanline IRQ Down-Counter

This block raises a CPU interrupt once a programmable number of scanlines has gone by. It counts rising edges of the pattern-bus A12 line. The graphics fetcher toggles that line about once per scanline. The CPU programs the block with writes in the top quarter of its address space. Address bit 13 picks one of two register pairs, and address bit 0 picks the register within the pair. The write data matters only for the reload value.

An 8-bit down-counter steps on each counting edge. When a reload has been requested, or when the counter is already zero, the counter takes the reload value instead of wrapping. If the counter is zero after the step and interrupts are enabled, a pending event is raised. The pending event starts a fixed five-step delay, and when the delay runs out the block emits a one-cycle IRQ pulse. Turning interrupts off also acknowledges an event that is pending in the same cycle.

Top module: `scanline_irq_counter`

## Requirements
- R1: Synchronous reset clears the reload value, the counter, the reload request, the enable bit, the pending flag and the delay, and holds `irq_pulse` low. After reset, counting edges produce no interrupt until an enable write is made.
- R2: A write with address bits [15:13] = 3'b110 and bit 0 = 0 stores `cpu_wdata` as the reload value. The current count is left unchanged.
- R3: A write with bits [15:13] = 3'b110 and bit 0 = 1 requests a reload, whatever the data. The counter takes the reload value at the next counting edge, not at the write, and that edge clears the request.
- R4: A counting edge is a clock in which `a12_sync` is 1 and was 0 in the previous clock. A level held high, or a falling transition, does not change the counter.
- R5: On a counting edge, the counter loads the reload value if a reload is requested or the count is zero. Otherwise it decrements by one. With reload value N and a reload request, the first interrupt follows counting edge N+1.
- R6: A pending event is raised only when the count after a counting edge is zero and the enable bit is set.
- R7: A write with bits [15:13] = 3'b111 and bit 0 = 0 clears the enable bit. It also drops a pending event that would be raised in the same clock.
- R8: A write with bits [15:13] = 3'b111 and bit 0 = 1 sets the enable bit.
- R9: `irq_pulse` goes high for exactly one clock, 5 clocks after the clock edge that took the counting edge raising the pending event.
- R10: A pending event that arrives while a delay is running is dropped. It does not restart the delay, so only one pulse results.
- R11: Writes whose address bits [15:14] are not 2'b11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write strobe, one clock per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| a12_sync | input | 1 | A12 line, already synchronized to clk |
| irq_pulse | output | 1 | Registered one-clock interrupt request |

## Verification
On every cycle, the assertions check the following:
- A reload write always leaves a reload request behind.
- The count moves only on a counting edge, and steps down by exactly one when it does not reload.
- An event is raised only while enabled.
- A disable write always clears the enable bit.
- A running delay is never restarted.
- An IRQ pulse never lasts two clocks.

Only the bench scenarios show the end-to-end figures: the N+1 edge count for each reload value, the exact 5-clock latency, the deferral of a reload request, and the rejection of out-of-range writes.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  // One-hot strobes decoded from a single CPU write
  typedef struct packed {
    logic set_reload_val;
    logic req_reload;
    logic irq_off;
    logic irq_on;
  } sirq_strobe_t;
endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output sirq_strobe_t      strb
);
  logic hit, upper_pair, odd;

  always_comb begin
    hit        = wr && (addr[ADDR_W-1 -: 2] == 2'b11);
    upper_pair = addr[ADDR_W-3];
    odd        = addr[0];
    strb.set_reload_val = hit && !upper_pair && !odd;
    strb.req_reload     = hit && !upper_pair &&  odd;
    strb.irq_off        = hit &&  upper_pair && !odd;
    strb.irq_on         = hit &&  upper_pair &&  odd;
  end
endmodule

// File: rtl/sirq_edge.sv
module sirq_edge (
  input  logic clk,
  input  logic rst,
  input  logic a12_in,
  output logic rise
);
  logic a12_prev;

  always_ff @(posedge clk) begin
    if (rst) a12_prev <= 1'b0;
    else     a12_prev <= a12_in;
  end

  assign rise = a12_in && !a12_prev;
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter
  import scanline_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sirq_strobe_t     strb,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic             pend
);
  logic [CNT_W-1:0] reload_val, cnt, cnt_next;
  logic             reload_req, en;

  always_comb begin
    if (reload_req || cnt == '0) cnt_next = reload_val;
    else                         cnt_next = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_val <= '0;
      cnt        <= '0;
      reload_req <= 1'b0;
      en         <= 1'b0;
      pend       <= 1'b0;
    end else begin
      if (strb.set_reload_val) reload_val <= wdata;
      if (tick) cnt <= cnt_next;
      if (strb.req_reload) reload_req <= 1'b1;
      else if (tick)       reload_req <= 1'b0;
      if (strb.irq_off)     en <= 1'b0;
      else if (strb.irq_on) en <= 1'b1;
      pend <= tick && (cnt_next == '0) && en && !strb.irq_off;
    end
  end

  // R3
  reload_flag_chk: assert property (@(posedge clk) disable iff (rst)
    strb.req_reload |=> reload_req);
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload_req && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  // R6
  pend_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> $past(en));
  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    strb.irq_off |=> !en);
endmodule

// File: rtl/sirq_delay.sv
module sirq_delay #(
  parameter int DELAY_STEPS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  output logic irq_q
);
  localparam int DLY_W = $clog2(DELAY_STEPS + 1);
  localparam logic [DLY_W-1:0] START = DLY_W'(DELAY_STEPS - 1);

  logic [DLY_W-1:0] dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly   <= '0;
      irq_q <= 1'b0;
    end else begin
      if (pend && dly == '0) dly <= START;
      else if (dly != '0)    dly <= dly - 1'b1;
      irq_q <= (dly == DLY_W'(1));
    end
  end

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && dly != '0) |=> (dly == $past(dly) - 1'b1));
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int DELAY_STEPS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              a12_sync,
  output logic              irq_pulse
);
  sirq_strobe_t strb;
  logic         tick, pend;

  sirq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr(cpu_wr), .addr(cpu_addr), .strb(strb)
  );

  sirq_edge u_edge (
    .clk(clk), .rst(rst), .a12_in(a12_sync), .rise(tick)
  );

  sirq_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .strb(strb), .wdata(cpu_wdata),
    .tick(tick), .pend(pend)
  );

  sirq_delay #(.DELAY_STEPS(DELAY_STEPS)) u_dly (
    .clk(clk), .rst(rst), .pend(pend), .irq_q(irq_pulse)
  );
endmodule

// File: tb/scanline_irq_counter_tb.sv
module scanline_irq_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        a12_sync = 1'b0;
  logic        irq_pulse;

  int n_chk = 0;
  int n_bad = 0;

  localparam int NVEC = 4;
  localparam int VEC_LATCH [NVEC] = '{0, 1, 2, 5};
  localparam int VEC_EDGE  [NVEC] = '{1, 2, 3, 6};
  localparam int LAT = 6;

  always #10 clk = ~clk;

  scanline_irq_counter u_dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .a12_sync(a12_sync), .irq_pulse(irq_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; a12_sync = 1'b0; cpu_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  // One A12 rise, then watch 12 negedges; first = negedge index of first high
  task automatic edge_obs(output int first, output int highs);
    first = 0; highs = 0;
    @(negedge clk); a12_sync = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 2) a12_sync = 1'b0;
      if (irq_pulse) begin
        highs++;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic arm(input logic [7:0] n);
    cpu_write(16'hC000, n);
    cpu_write(16'hC001, 8'h00);
    cpu_write(16'hE001, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f, h, fired, tot, lat;
    do_reset();
    @(negedge clk);
    chk(irq_pulse == 1'b0, "R1 reset output", irq_pulse, 0);

    // R1: after reset, edges give no interrupt until enabled
    tot = 0;
    for (int e = 0; e < 3; e++) begin edge_obs(f, h); tot += h; end
    chk(tot == 0, "R1 no irq before enable", tot, 0);

    // Vector table: R5 edge count, R9 latency and width
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      arm(VEC_LATCH[v][7:0]);
      fired = 0; tot = 0; lat = 0;
      for (int e = 1; e <= VEC_EDGE[v]; e++) begin
        edge_obs(f, h);
        tot += h;
        if (h != 0 && fired == 0) begin fired = e; lat = f; end
      end
      chk(fired == VEC_EDGE[v], "R5 first irq edge", fired, VEC_EDGE[v]);
      chk(tot == 1 && lat == LAT, "R9 pulse width/latency", tot * 100 + lat, 100 + LAT);
    end

    // R2/R3: a new reload value without a request is used only at the next zero reload
    do_reset();
    arm(8'd1);
    edge_obs(f, h);                      // cnt=1
    cpu_write(16'hC000, 8'd3);           // R2: reload value 3, count kept
    edge_obs(f, h);                      // cnt=0 -> irq
    chk(h == 1, "R2 count kept after value write", h, 1);
    tot = 0;
    for (int e = 0; e < 3; e++) begin edge_obs(f, h); tot += h; end  // 3,2,1
    chk(tot == 0, "R2 new value used on reload", tot, 0);
    edge_obs(f, h);                      // 0
    chk(h == 1, "R2 irq after new period", h, 1);

    // R3: reload request is deferred to next edge
    edge_obs(f, h);                      // reload 3
    cpu_write(16'hC000, 8'd0);
    cpu_write(16'hC001, 8'h55);          // request; count stays 3 until edge
    edge_obs(f, h);                      // reload to 0 -> irq
    chk(h == 1, "R3 deferred reload", h, 1);

    // R4: long high level counts once
    do_reset();
    arm(8'd2);
    @(negedge clk); a12_sync = 1'b1;     // edge 1: cnt=2
    repeat (20) @(negedge clk);
    a12_sync = 1'b0;
    repeat (10) @(negedge clk);
    edge_obs(f, h);                      // edge 2: cnt=1
    chk(h == 0, "R4 level not counted", h, 0);
    edge_obs(f, h);                      // edge 3: cnt=0
    chk(h == 1, "R4 irq on third rise", h, 1);

    // R6/R8: disabled events dropped; enable allows them
    do_reset();
    cpu_write(16'hC001, 8'h00);
    edge_obs(f, h);
    chk(h == 0, "R6 no irq while disabled", h, 0);
    cpu_write(16'hE001, 8'h00);
    edge_obs(f, h);
    chk(h == 1, "R8 enable write", h, 1);

    // R7: disable in the same clock as the raising edge
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = 16'hE000; a12_sync = 1'b1;
    tot = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk); cpu_wr = 1'b0;
      if (k == 2) a12_sync = 1'b0;
      if (irq_pulse) tot++;
    end
    chk(tot == 0, "R7 same-cycle acknowledge", tot, 0);
    edge_obs(f, h);
    chk(h == 0, "R7 stays disabled", h, 0);

    // R10: second event during running delay is dropped
    do_reset();
    arm(8'd0);
    @(negedge clk); a12_sync = 1'b1;
    @(negedge clk); a12_sync = 1'b0;
    @(negedge clk); a12_sync = 1'b1;
    @(negedge clk); a12_sync = 1'b0;
    tot = 0;
    for (int k = 0; k < 14; k++) begin @(negedge clk); if (irq_pulse) tot++; end
    chk(tot == 1, "R10 no restart", tot, 1);

    // R11: out-of-range writes ignored
    do_reset();
    cpu_write(16'h6001, 8'h00);
    cpu_write(16'hA001, 8'h00);
    cpu_write(16'h2001, 8'h00);
    edge_obs(f, h);
    chk(h == 0, "R11 out-of-range enable ignored", h, 0);
    cpu_write(16'hE001, 8'h00);
    cpu_write(16'h4000, 8'd2);
    cpu_write(16'h4001, 8'h00);
    edge_obs(f, h);
    chk(h == 1, "R11 out-of-range value ignored", h, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule